// File: doc/BRIEF.md
# Read-only serial EEPROM reader

This block is a single-master I2C controller that can only read from one serial EEPROM. A one-cycle start strobe captures a 7-bit device address, a 16-bit word address, a byte count and a speed select. The block first writes the word address to the device, then issues a repeated START and streams the requested number of bytes out on a byte-valid interface. When the transfer ends it pulses done.

Both bus lines are open-drain. The block only ever pulls a line low or releases it. SCL timing comes entirely from a prescaler on the system clock, at 100 kHz or 400 kHz, and the block does not look at the SCL wire. The block never writes data to the device, and it never arbitrates. If any byte the master sends is not acknowledged, the transfer is aborted through a STOP and an error flag is raised.

Top module: `eeprom_rd_master`

## Requirements
- R1: After reset both line enables (`scl_oe_o`, `sda_oe_o`, 1 = pull low) are 0, and `byte_valid_o`, `done_o` and `err_o` are 0.
- R2: A transfer is performed in this order:
  - START;
  - the byte {dev_addr_i, 0};
  - word address bits 15:8;
  - word address bits 7:0;
  - repeated START;
  - the byte {dev_addr_i, 1};
  - the data bytes;
  - exactly one STOP.
- R3: Each data byte is received MSB first and is presented on `data_o` with a one-cycle `byte_valid_o` pulse. The number of bytes equals `len_i`, and a `len_i` of 0 reads one byte. The bytes come from consecutive word addresses.
- R4: The master ACKs every data byte except the last, NACKs the last byte, and then sends STOP. `done_o` pulses for one cycle after the STOP, with both lines released.
- R5: A NACK on any of the four bytes the master sends ends the transfer with STOP and sets `err_o`, and no data byte is produced. `err_o` stays set until the next accepted start and is 0 after a clean transfer.
- R6: The SCL period is 4*floor(CLK_HZ/400000) system clocks when `fast_i` is 0, and 4*floor(CLK_HZ/1600000) system clocks when `fast_i` is 1. `fast_i` is sampled with the start strobe.
- R7: While SCL stays released, SDA changes only as part of a START (falling) or a STOP (rising).
- R8: A start strobe that arrives while a transfer is in progress is ignored. The running transfer's address, count and data are unaffected, and only one done pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| dev_addr_i | input | 7 | EEPROM device address |
| word_addr_i | input | 16 | First word address to read |
| len_i | input | CNT_W | Number of bytes to read (0 reads one) |
| fast_i | input | 1 | 1 = 400 kHz SCL, 0 = 100 kHz SCL |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_oe_o | output | 1 | 1 = pull SCL low, 0 = release |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| data_o | output | 8 | Received data byte |
| byte_valid_o | output | 1 | One-cycle strobe for `data_o` |
| done_o | output | 1 | One-cycle pulse at transfer end |
| err_o | output | 1 | NACK seen during the last transfer |

## Verification
The following are checked on every cycle:
- the SDA-versus-SCL rule, so that SDA moves under a high SCL only in START or STOP states;
- the single-cycle width of the byte and done strobes;
- that both lines are released when done fires;
- that no byte is delivered once a NACK has been flagged;
- that a strobe during a busy transfer leaves the captured word address untouched.

The other behaviours need the bench's EEPROM model and scenarios:
- the exact byte order on the wire and the high-byte-first word address;
- the ACK/NACK pattern on data;
- the SCL period at each speed;
- the zero-length rule;
- the abort at each of the four NACK points;
- address increment across a 256-byte boundary.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;
  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WR, CMD_RD} bus_cmd_e;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_WR, S_WACK, S_RSTART, S_RD, S_MACK, S_STOP
  } seq_state_e;
endpackage

// File: rtl/i2crd_tick.sv
module i2crd_tick #(
  parameter int unsigned SLOW_DIV = 125,
  parameter int unsigned FAST_DIV = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(SLOW_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim    = fast_i ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2crd_phy.sv
// One bus command per four quarter ticks: q0/q1 SCL low, q2/q3 SCL high.
module i2crd_phy
  import i2crd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     cmd_valid_i,
  input  bus_cmd_e cmd_i,
  input  logic     bit_i,
  input  logic     sda_i,
  output logic     idle_o,
  output logic     done_o,
  output logic     rx_o,
  output logic     scl_oe_o,
  output logic     sda_oe_o
);
  logic     busy_q, bit_q, lvl_q, rx_q;
  bus_cmd_e cmd_q;
  logic [1:0] q_q;
  logic scl_hi, sda_hi;

  // Between commands SCL stays high and SDA holds its last level.
  always_comb begin
    scl_hi = 1'b1;
    sda_hi = lvl_q;
    if (busy_q) begin
      scl_hi = q_q[1];
      if (q_q != 2'd0) begin
        unique case (cmd_q)
          CMD_START: sda_hi = (q_q != 2'd3);
          CMD_STOP:  sda_hi = (q_q == 2'd3);
          CMD_WR:    sda_hi = bit_q;
          default:   sda_hi = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmd_q  <= CMD_STOP;
      q_q    <= 2'd0;
      bit_q  <= 1'b1;
      lvl_q  <= 1'b1;
      rx_q   <= 1'b1;
    end else if (!busy_q) begin
      if (cmd_valid_i) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd_i;
        bit_q  <= bit_i;
        q_q    <= 2'd0;
      end
    end else if (tick_i) begin
      if (q_q == 2'd2) rx_q <= sda_i;
      if (q_q == 2'd3) begin
        busy_q <= 1'b0;
        lvl_q  <= sda_hi;
      end
      q_q <= q_q + 2'd1;
    end
  end

  assign idle_o   = ~busy_q;
  assign done_o   = busy_q & tick_i & (q_q == 2'd3);
  assign rx_o     = rx_q;
  assign scl_oe_o = ~scl_hi;
  assign sda_oe_o = ~sda_hi;
endmodule

// File: rtl/eeprom_rd_master.sv
module eeprom_rd_master
  import i2crd_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [15:0]      word_addr_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             fast_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic [7:0]       data_o,
  output logic             byte_valid_o,
  output logic             done_o,
  output logic             err_o
);
  // FAST_DIV must be at least 2 to keep the SCL period exact.
  localparam int unsigned SLOW_DIV = CLK_HZ / 400_000;
  localparam int unsigned FAST_DIV = CLK_HZ / 1_600_000;

  seq_state_e       state_q;
  logic [7:0]       shreg_q;
  logic [2:0]       bitcnt_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] left_q;
  logic [6:0]       dev_q;
  logic [15:0]      addr_q;
  logic             fast_q, err_q, done_q, bvalid_q;
  logic [7:0]       data_q;

  logic     tick, phy_idle, phy_done, phy_rx, cmd_valid, cmd_bit;
  bus_cmd_e cmd;

  i2crd_tick #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_tick (
    .clk_i, .rst_ni, .fast_i(fast_q), .tick_o(tick)
  );

  i2crd_phy u_phy (
    .clk_i, .rst_ni, .tick_i(tick), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .bit_i(cmd_bit), .sda_i, .idle_o(phy_idle), .done_o(phy_done),
    .rx_o(phy_rx), .scl_oe_o, .sda_oe_o
  );

  always_comb begin
    cmd       = CMD_RD;
    cmd_bit   = 1'b1;
    cmd_valid = phy_idle && (state_q != S_IDLE);
    unique case (state_q)
      S_START, S_RSTART: cmd = CMD_START;
      S_WR: begin
        cmd     = CMD_WR;
        cmd_bit = shreg_q[7];
      end
      S_MACK: begin
        cmd     = CMD_WR;
        cmd_bit = (left_q == CNT_W'(1));  // NACK the last byte
      end
      S_STOP:  cmd = CMD_STOP;
      default: cmd = CMD_RD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      sel_q    <= '0;
      left_q   <= '0;
      dev_q    <= '0;
      addr_q   <= '0;
      fast_q   <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      bvalid_q <= 1'b0;
      data_q   <= '0;
    end else begin
      done_q   <= 1'b0;
      bvalid_q <= 1'b0;
      if (state_q == S_IDLE) begin
        if (start_i) begin
          dev_q    <= dev_addr_i;
          addr_q   <= word_addr_i;
          fast_q   <= fast_i;
          left_q   <= (len_i == '0) ? CNT_W'(1) : len_i;
          err_q    <= 1'b0;
          bitcnt_q <= '0;
          state_q  <= S_START;
        end
      end else if (phy_done) begin
        unique case (state_q)
          S_START: begin
            shreg_q <= {dev_q, 1'b0};
            sel_q   <= 2'd0;
            state_q <= S_WR;
          end
          S_RSTART: begin
            shreg_q <= {dev_q, 1'b1};
            sel_q   <= 2'd3;
            state_q <= S_WR;
          end
          S_WR: begin
            shreg_q  <= {shreg_q[6:0], 1'b0};
            bitcnt_q <= bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) state_q <= S_WACK;
          end
          S_WACK: begin
            if (phy_rx) begin
              err_q   <= 1'b1;
              state_q <= S_STOP;
            end else begin
              unique case (sel_q)
                2'd0: begin shreg_q <= addr_q[15:8]; sel_q <= 2'd1; state_q <= S_WR; end
                2'd1: begin shreg_q <= addr_q[7:0];  sel_q <= 2'd2; state_q <= S_WR; end
                2'd2: state_q <= S_RSTART;
                default: state_q <= S_RD;
              endcase
            end
          end
          S_RD: begin
            shreg_q  <= {shreg_q[6:0], phy_rx};
            bitcnt_q <= bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) begin
              data_q   <= {shreg_q[6:0], phy_rx};
              bvalid_q <= 1'b1;
              state_q  <= S_MACK;
            end
          end
          S_MACK: begin
            if (left_q == CNT_W'(1)) state_q <= S_STOP;
            else begin
              left_q  <= left_q - 1'b1;
              state_q <= S_RD;
            end
          end
          default: begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        endcase
      end
    end
  end

  assign data_o       = data_q;
  assign byte_valid_o = bvalid_q;
  assign done_o       = done_q;
  assign err_o        = err_q;
endmodule

// File: rtl/i2crd_chk.sv
module i2crd_chk
  import i2crd_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        scl_oe_o,
  input logic        sda_oe_o,
  input logic        byte_valid_o,
  input logic        done_o,
  input logic        err_o,
  input seq_state_e  state_q,
  input logic [15:0] addr_q
);
  assert_sda_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && !$past(scl_oe_o) && (sda_oe_o != $past(sda_oe_o)))
      |-> (state_q inside {S_START, S_RSTART, S_STOP}));

  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!scl_oe_o && !sda_oe_o));

  assert_no_data_after_nack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !byte_valid_o);

  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != S_IDLE) |=> $stable(addr_q));
endmodule

bind eeprom_rd_master i2crd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .scl_oe_o(scl_oe_o),
  .sda_oe_o(sda_oe_o), .byte_valid_o(byte_valid_o), .done_o(done_o),
  .err_o(err_o), .state_q(state_q), .addr_q(addr_q)
);

// File: tb/sim_eeprom_rd_master.sv
module sim_eeprom_rd_master;
  localparam int CLK_HZ   = 3_200_000;
  localparam int CNT_W    = 8;
  localparam int SLOW_BIT = 4 * (CLK_HZ / 400_000);
  localparam int FAST_BIT = 4 * (CLK_HZ / 1_600_000);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic             start = 1'b0, fast = 1'b0;
  logic [6:0]       dev = '0;
  logic [15:0]      addr = '0;
  logic [CNT_W-1:0] len = '0;
  logic             scl_oe, sda_oe, bvalid, done, err;
  logic [7:0]       data;
  logic             slave_pull = 1'b0;
  logic             scl_bus, sda_bus;
  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | slave_pull);

  eeprom_rd_master #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_addr_i(dev),
    .word_addr_i(addr), .len_i(len), .fast_i(fast), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .data_o(data),
    .byte_valid_o(bvalid), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  function automatic logic [7:0] mem_at(logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [6:0]  slv_dev = 7'h50;
  int          nack_at = -1;
  logic [15:0] slv_ptr = '0;
  logic [7:0]  wr_log[4];
  int n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0;

  initial begin : eeprom_model
    logic ps, pd, rd_mode, go_read, ack_this, last_ack;
    int bc, widx;
    logic [7:0] sh, tx;
    ps = 1; pd = 1; rd_mode = 0; go_read = 0; ack_this = 0; last_ack = 0;
    bc = 0; widx = 0; sh = '0; tx = '0;
    forever begin
      @(scl_bus or sda_bus);
      if (scl_bus && ps && pd && !sda_bus) begin
        n_start++; bc = 0; rd_mode = 0; go_read = 0; slave_pull = 0;
      end else if (scl_bus && ps && !pd && sda_bus) begin
        n_stop++; bc = 0; rd_mode = 0; go_read = 0; widx = 0; slave_pull = 0;
      end else if (scl_bus && !ps) begin
        bc++;
        if (!rd_mode && bc <= 8) sh = {sh[6:0], sda_bus};
        if (rd_mode && bc == 9) begin
          last_ack = !sda_bus;
          if (sda_bus) n_mnack++; else n_mack++;
        end
      end else if (!scl_bus && ps) begin
        if (!rd_mode) begin
          if (bc == 8) begin
            ack_this = (widx != nack_at);
            if ((widx == 0 || widx == 3) && sh[7:1] != slv_dev) ack_this = 0;
            if (widx < 4) wr_log[widx] = sh;
            if (widx == 1) slv_ptr[15:8] = sh;
            if (widx == 2) slv_ptr[7:0] = sh;
            if (ack_this && sh[0] && sh[7:1] == slv_dev) go_read = 1;
            slave_pull = ack_this;
            widx++;
          end else if (bc == 9) begin
            slave_pull = 0; bc = 0;
            if (go_read) begin
              rd_mode = 1; tx = mem_at(slv_ptr); slave_pull = ~tx[7];
            end
          end
        end else begin
          if (bc >= 1 && bc <= 7) slave_pull = ~tx[7-bc];
          else if (bc == 8) slave_pull = 0;
          else if (bc == 9) begin
            bc = 0; slv_ptr++;
            if (last_ack) begin tx = mem_at(slv_ptr); slave_pull = ~tx[7]; end
            else rd_mode = 0;
          end
        end
      end
      ps = scl_bus; pd = sda_bus;
    end
  end

  // ---------------- monitor ----------------
  int cyc = 0, rx_cnt = 0, done_cnt = 0, last_rise = 0, per_min = 0, per_max = 0;
  bit have_rise = 0;
  logic scl_prev = 1'b1;
  always @(posedge clk) cyc++;

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (bvalid) begin
        rx_cnt++;
        if (exp_q.size() == 0) check("R3", "unexpected byte", int'(data), -1);
        else check("R3", "data byte", int'(data), int'(exp_q.pop_front()));
      end
      if (done) done_cnt++;
      if (scl_bus && !scl_prev) begin
        if (have_rise) begin
          if (cyc - last_rise < per_min) per_min = cyc - last_rise;
          if (cyc - last_rise > per_max) per_max = cyc - last_rise;
        end
        last_rise = cyc; have_rise = 1;
      end
      scl_prev = scl_bus;
    end
  end

  // ---------------- driver ----------------
  task automatic run_xfer(logic [6:0] dv, logic [15:0] ad, int ln, logic fs, int nk, bit poke);
    int n, guard;
    bit exp_err;
    exp_err = (dv != slv_dev) || (nk >= 0);
    n = (ln == 0) ? 1 : ln;
    nack_at = nk;
    n_start = 0; n_stop = 0; n_mack = 0; n_mnack = 0;
    rx_cnt = 0; done_cnt = 0; have_rise = 0; per_min = 1_000_000; per_max = 0;
    if (!exp_err) for (int i = 0; i < n; i++) exp_q.push_back(mem_at(ad + 16'(i)));
    @(negedge clk);
    dev = dv; addr = ad; len = CNT_W'(ln); fast = fs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      addr = ~ad; len = 8'd9; fast = ~fs; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 60000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    check("R5", "err flag", int'(err), int'(exp_err));
    check("R3", "byte count", rx_cnt, exp_err ? 0 : n);
    check("R3", "bytes left unreceived", exp_q.size(), 0);
    exp_q.delete();
    check(poke ? "R8" : "R4", "done pulses", done_cnt, 1);
    check("R4", "lines released", int'({scl_oe, sda_oe}), 0);
    check("R2", "stop count", n_stop, 1);
    if (!exp_err) begin
      check("R2", "start count", n_start, 2);
      check("R2", "device write byte", int'(wr_log[0]), int'({dv, 1'b0}));
      check("R2", "address high byte", int'(wr_log[1]), int'(ad[15:8]));
      check("R2", "address low byte", int'(wr_log[2]), int'(ad[7:0]));
      check("R2", "device read byte", int'(wr_log[3]), int'({dv, 1'b1}));
      check("R4", "master acks", n_mack, n - 1);
      check("R4", "master nacks", n_mnack, 1);
      check("R6", "scl period min", per_min, fs ? FAST_BIT : SLOW_BIT);
      check("R6", "scl period max", per_max, fs ? FAST_BIT : SLOW_BIT);
    end
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1", "scl_oe in reset", int'(scl_oe), 0);
    check("R1", "sda_oe in reset", int'(sda_oe), 0);
    check("R1", "strobes in reset", int'({bvalid, done, err}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "idle lines after reset", int'({scl_oe, sda_oe}), 0);

    run_xfer(7'h50, 16'h1234, 4, 1'b0, -1, 0);   // R3 slow stream
    run_xfer(7'h50, 16'h00FE, 3, 1'b1, -1, 0);   // R6 fast, address crosses 0x0100
    run_xfer(7'h50, 16'hABCD, 0, 1'b1, -1, 0);   // R3 zero length reads one
    run_xfer(7'h50, 16'h0001, 1, 1'b0, -1, 0);   // R4 single byte NACKed
    run_xfer(7'h51, 16'h0100, 2, 1'b1, -1, 0);   // R5 wrong device NACK
    repeat (20) @(negedge clk);
    check("R5", "err held after abort", int'(err), 1);
    run_xfer(7'h50, 16'h0200, 2, 1'b1, 1, 0);    // R5 NACK on high address
    run_xfer(7'h50, 16'h0300, 2, 1'b1, 2, 0);    // R5 NACK on low address
    run_xfer(7'h50, 16'h0400, 2, 1'b1, 3, 0);    // R5 NACK on read select
    run_xfer(7'h50, 16'h4321, 2, 1'b1, -1, 0);   // R5 clean clears err
    run_xfer(7'h50, 16'h0F0F, 3, 1'b0, -1, 1);   // R8 strobe while busy
    check("R7", "bus idle at end", int'({scl_bus, sda_bus}), 3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule